// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment-plus-offset memory request into a linear address and judges whether the access may proceed. It holds six segment slots. Each slot is a hidden cache of base, limit, privilege level and a writable flag. Address formation and every check read only these caches. A write to a slot refills its cache at once, and the refill depends on the current mode. With protection off, the 16-bit value sets the base to value×16 and the limit to 0xFFFF. With protection on, the caller supplies a descriptor it has already fetched, and that descriptor goes straight into the cache.

A request names an access kind and an offset. For ordinary data accesses it may also name an override segment. The unit picks the segment, adds the cached base to the offset, and tests the offset against the cached limit. It also tests the privilege level taken from the code slot and the writable flag. One cycle later it reports either a valid address or a fault.

Caches are never flushed when the mode changes. A descriptor loaded under protection therefore keeps its 32-bit base and limit after protection is switched off, until that slot is written again.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every cache holds base 0, limit 0xFFFF, privilege level 0 and writable. All outputs are low until the first request.
- R2: With `peMode` low, writing value V into slot S sets the base of S to V×16 and its limit to 0xFFFF. The limit cannot be raised in this mode; such a write always sets it to 0xFFFF.
- R3: With `peMode` low and `a20En` low, bit 20 of the produced address is forced to 0, so a paragraph sum above 1 MiB wraps. With `a20En` high, bit 20 is kept.
- R4: Slot codes are: 0 extra, 1 code, 2 stack, 3 data, 4 and 5 general. Access kinds are: 0 data, 1 code fetch, 2 stack, 3 string destination. Kinds 1, 2 and 3 always use slots 1, 2 and 0, whatever the override inputs say.
- R5: A kind-0 access uses slot 3, unless `reqOvrEn` is high and `reqOvrSeg` is 0 to 5, in which case that slot is used. Override codes 6 and 7 fall back to slot 3.
- R6: With `peMode` high, a write loads the supplied base, limit, privilege level and writable flag. The address is the base plus the offset, modulo 2^32.
- R7: An offset greater than the selected cached limit raises `outLimitFault` and keeps `outValid` low. An offset equal to the limit is allowed.
- R8: With `peMode` high, a kind-0 or kind-3 access raises `outProtFault` when the privilege level cached in the code slot is numerically greater than the selected slot's level. Code fetches and stack accesses have no privilege test. Nothing is tested with `peMode` low.
- R9: With `peMode` high, a write access (`reqWrite` high) of kind 0, 2 or 3 to a slot whose writable flag is clear raises `outProtFault`.
- R10: When `peMode` goes low, a cache loaded under protection keeps its base and limit until that slot is written again.
- R11: When a slot write and a request that uses that slot happen in the same cycle, the request sees the new cache, including a new code-slot privilege level.
- R12: Results appear exactly one cycle after the request. In a cycle with no request, `outValid` and both fault outputs are low.
- R13: A write with slot code 6 or 7 changes no cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| peMode | input | 1 | Protection enabled |
| a20En | input | 1 | Keep address bit 20 while protection is off |
| wrEn | input | 1 | Slot write strobe |
| wrSeg | input | 3 | Slot code for the write |
| wrSel | input | 16 | Visible value written (used for paragraph base when protection is off) |
| wrBase | input | 32 | Fetched descriptor base |
| wrLimit | input | 32 | Fetched descriptor maximum offset |
| wrDpl | input | 2 | Fetched descriptor privilege level |
| wrWritable | input | 1 | Fetched descriptor allows writes |
| reqValid | input | 1 | Translation request |
| reqKind | input | 2 | Access kind |
| reqOvrEn | input | 1 | Override present (kind 0 only) |
| reqOvrSeg | input | 3 | Override slot code |
| reqOffset | input | 32 | Offset within the segment |
| reqWrite | input | 1 | Access is a write |
| outValid | output | 1 | Address is valid and allowed |
| outAddr | output | 32 | Linear address |
| outLimitFault | output | 1 | Offset beyond limit |
| outProtFault | output | 1 | Privilege or write-permission fault |

## Verification
The assertions check several rules on every cycle. A request is always answered one cycle later by a valid address or a fault, and an idle cycle produces nothing. A fault never comes with a valid strobe. Bit 20 stays clear while protection is off and the gate is low. No privilege fault can come from a code fetch or from an access with protection off. At most one slot loads per cycle. Other behaviour depends on history, and only the bench scenarios can show it. This covers the paragraph bases, default and override segment selection, privilege level comparisons and limit boundaries. It also covers caches that survive a mode change and the write-first ordering of a same-cycle load.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
  localparam int SEG_CNT   = 6;
  localparam int SEG_IDX_W = 3;

  // slot codes: decoded by both write and override paths
  localparam logic [SEG_IDX_W-1:0] SLOT_EXTRA = 3'd0;
  localparam logic [SEG_IDX_W-1:0] SLOT_CODE  = 3'd1;
  localparam logic [SEG_IDX_W-1:0] SLOT_STACK = 3'd2;
  localparam logic [SEG_IDX_W-1:0] SLOT_DATA  = 3'd3;

  typedef enum logic [1:0] {
    KIND_DATA   = 2'd0,
    KIND_FETCH  = 2'd1,
    KIND_STACK  = 2'd2,
    KIND_STRDST = 2'd3
  } accKind_e;

  typedef struct packed {
    logic [SEG_CNT-1:0]   loadMask;
    logic [SEG_IDX_W-1:0] segSel;
    logic                 realLoad;
    logic                 fire;
    logic                 chkPriv;
    logic                 chkWrite;
    logic                 maskA20;
  } ctrlStrobe_t;
endpackage

// File: rtl/seg_ctrl.sv
`timescale 1ns/1ps
module seg_ctrl
  import seg_xlate_pkg::*;
(
  input  logic                 peMode,
  input  logic                 a20En,
  input  logic                 wrEn,
  input  logic [SEG_IDX_W-1:0] wrSeg,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic                 reqOvrEn,
  input  logic [SEG_IDX_W-1:0] reqOvrSeg,
  input  logic                 reqWrite,
  output ctrlStrobe_t          strobe
);
  logic [SEG_CNT-1:0]   loadBits;
  logic [SEG_IDX_W-1:0] pick;
  accKind_e             kind;

  assign kind = accKind_e'(reqKind);

  // one strobe per slot; codes past the last slot match nothing
  for (genvar i = 0; i < SEG_CNT; i++) begin : g_load
    assign loadBits[i] = wrEn && (wrSeg == SEG_IDX_W'(i));
  end

  always_comb begin
    unique case (kind)
      KIND_FETCH:  pick = SLOT_CODE;
      KIND_STACK:  pick = SLOT_STACK;
      KIND_STRDST: pick = SLOT_EXTRA;
      default:     pick = (reqOvrEn && (reqOvrSeg < SEG_IDX_W'(SEG_CNT))) ? reqOvrSeg : SLOT_DATA;
    endcase
  end

  always_comb begin
    strobe.loadMask = loadBits;
    strobe.segSel   = pick;
    strobe.realLoad = !peMode;
    strobe.fire     = reqValid;
    strobe.chkPriv  = peMode && ((kind == KIND_DATA) || (kind == KIND_STRDST));
    strobe.chkWrite = peMode && reqWrite && (kind != KIND_FETCH);
    strobe.maskA20  = !peMode && !a20En;
  end
endmodule

// File: rtl/seg_dp.sv
`timescale 1ns/1ps
module seg_dp
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 16,
  parameter int PARA_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrLimit,
  input  logic [1:0]        wrDpl,
  input  logic              wrWritable,
  input  logic [ADDR_W-1:0] reqOffset,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outLimitFault,
  output logic              outProtFault
);
  localparam logic [SEL_W-1:0] REAL_LIMIT = '1;
  localparam int               A20_BIT    = SEL_W + PARA_SHIFT;

  logic [ADDR_W-1:0] cBase  [SEG_CNT];
  logic [ADDR_W-1:0] cLimit [SEG_CNT];
  logic [1:0]        cDpl   [SEG_CNT];
  logic              cWr    [SEG_CNT];

  logic [ADDR_W-1:0] nBase, nLimit, eBase, eLimit, sum;
  logic [1:0]        nDpl, eDpl, cpl;
  logic              nWr, eWr, hitNew, limFault, privFault, wrFault;

  // content a write installs, by mode
  always_comb begin
    nBase  = strobe.realLoad ? ADDR_W'({wrSel, {PARA_SHIFT{1'b0}}}) : wrBase;
    nLimit = strobe.realLoad ? ADDR_W'(REAL_LIMIT) : wrLimit;
    nDpl   = strobe.realLoad ? 2'd0 : wrDpl;
    nWr    = strobe.realLoad ? 1'b1 : wrWritable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SEG_CNT; s++) begin
        cBase[s]  <= '0;
        cLimit[s] <= ADDR_W'(REAL_LIMIT);
        cDpl[s]   <= '0;
        cWr[s]    <= 1'b1;
      end
    end else begin
      for (int s = 0; s < SEG_CNT; s++) begin
        if (strobe.loadMask[s]) begin
          cBase[s]  <= nBase;
          cLimit[s] <= nLimit;
          cDpl[s]   <= nDpl;
          cWr[s]    <= nWr;
        end
      end
    end
  end

  // write-first bypass for the selected slot and the code slot
  always_comb begin
    hitNew = strobe.loadMask[strobe.segSel];
    eBase  = hitNew ? nBase  : cBase[strobe.segSel];
    eLimit = hitNew ? nLimit : cLimit[strobe.segSel];
    eDpl   = hitNew ? nDpl   : cDpl[strobe.segSel];
    eWr    = hitNew ? nWr    : cWr[strobe.segSel];
    cpl    = strobe.loadMask[SLOT_CODE] ? nDpl : cDpl[SLOT_CODE];
  end

  always_comb begin
    sum = eBase + reqOffset;
    if (strobe.maskA20) sum[A20_BIT] = 1'b0;
    limFault  = reqOffset > eLimit;
    privFault = strobe.chkPriv && (cpl > eDpl);
    wrFault   = strobe.chkWrite && !eWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outAddr       <= '0;
      outLimitFault <= 1'b0;
      outProtFault  <= 1'b0;
    end else begin
      outValid      <= strobe.fire && !limFault && !privFault && !wrFault;
      outLimitFault <= strobe.fire && limFault;
      outProtFault  <= strobe.fire && (privFault || wrFault);
      if (strobe.fire) outAddr <= sum;
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 peMode,
  input  logic                 a20En,
  input  logic                 wrEn,
  input  logic [SEG_IDX_W-1:0] wrSeg,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic [ADDR_W-1:0]    wrBase,
  input  logic [ADDR_W-1:0]    wrLimit,
  input  logic [1:0]           wrDpl,
  input  logic                 wrWritable,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic                 reqOvrEn,
  input  logic [SEG_IDX_W-1:0] reqOvrSeg,
  input  logic [ADDR_W-1:0]    reqOffset,
  input  logic                 reqWrite,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outAddr,
  output logic                 outLimitFault,
  output logic                 outProtFault
);
  ctrlStrobe_t ctrlStrobe;

  seg_ctrl u_ctrl (
    .peMode(peMode), .a20En(a20En), .wrEn(wrEn), .wrSeg(wrSeg),
    .reqValid(reqValid), .reqKind(reqKind), .reqOvrEn(reqOvrEn),
    .reqOvrSeg(reqOvrSeg), .reqWrite(reqWrite), .strobe(ctrlStrobe)
  );

  seg_dp #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .wrSel(wrSel),
    .wrBase(wrBase), .wrLimit(wrLimit), .wrDpl(wrDpl), .wrWritable(wrWritable),
    .reqOffset(reqOffset), .outValid(outValid), .outAddr(outAddr),
    .outLimitFault(outLimitFault), .outProtFault(outProtFault)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int A20_BIT = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               peMode,
  input logic               a20En,
  input logic               reqValid,
  input logic [1:0]         reqKind,
  input logic [SEG_CNT-1:0] loadMask,
  input logic               outValid,
  input logic [ADDR_W-1:0]  outAddr,
  input logic               outLimitFault,
  input logic               outProtFault
);
  p_single_load_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadMask));

  p_limit_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    outLimitFault |-> !outValid);

  p_prot_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    outProtFault |-> !outValid);

  p_answer_next_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (outValid || outLimitFault || outProtFault));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(outValid || outLimitFault || outProtFault));

  p_a20_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !peMode && !a20En) |=> !outAddr[A20_BIT]);

  p_real_noprot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !peMode) |=> !outProtFault);

  p_fetch_noprot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd1) |=> !outProtFault);
endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W), .A20_BIT(SEL_W + 4)) u_chk (
  .clk(clk), .rstN(rstN), .peMode(peMode), .a20En(a20En),
  .reqValid(reqValid), .reqKind(reqKind), .loadMask(ctrlStrobe.loadMask),
  .outValid(outValid), .outAddr(outAddr),
  .outLimitFault(outLimitFault), .outProtFault(outProtFault)
);

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;

  logic clk = 1'b0, rstN = 1'b0, peMode = 1'b0, a20En = 1'b0;
  logic wrEn = 1'b0, wrWritable = 1'b0, reqValid = 1'b0, reqOvrEn = 1'b0, reqWrite = 1'b0;
  logic [2:0] wrSeg = '0, reqOvrSeg = '0;
  logic [SEL_W-1:0] wrSel = '0;
  logic [ADDR_W-1:0] wrBase = '0, wrLimit = '0, reqOffset = '0;
  logic [1:0] wrDpl = '0, reqKind = '0;
  logic outValid, outLimitFault, outProtFault;
  logic [ADDR_W-1:0] outAddr;

  seg_xlate_unit #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rstN(rstN), .peMode(peMode), .a20En(a20En), .wrEn(wrEn),
    .wrSeg(wrSeg), .wrSel(wrSel), .wrBase(wrBase), .wrLimit(wrLimit),
    .wrDpl(wrDpl), .wrWritable(wrWritable), .reqValid(reqValid),
    .reqKind(reqKind), .reqOvrEn(reqOvrEn), .reqOvrSeg(reqOvrSeg),
    .reqOffset(reqOffset), .reqWrite(reqWrite), .outValid(outValid),
    .outAddr(outAddr), .outLimitFault(outLimitFault), .outProtFault(outProtFault)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // reference cache contents, derived from the requirements
  logic [31:0] mBase [6];
  logic [31:0] mLimit[6];
  logic [1:0]  mDpl  [6];
  bit          mWr   [6];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pickSeg(input int kind, input bit oEn, input int oSeg);
    if (kind == 1) return 1;
    if (kind == 2) return 2;
    if (kind == 3) return 0;
    if (oEn && oSeg < 6) return oSeg;
    return 3;
  endfunction

  task automatic step(input bit doWr, input int wseg, input logic [15:0] wsel,
                      input logic [31:0] wbase, input logic [31:0] wlim,
                      input logic [1:0] wdpl, input bit wwr,
                      input bit doReq, input int kind, input bit oEn, input int oSeg,
                      input logic [31:0] off, input bit wrt, input string tag);
    int s;
    logic [31:0] eAddr;
    bit eLim, eProt;
    @(negedge clk);
    wrEn = doWr; wrSeg = 3'(wseg); wrSel = wsel; wrBase = wbase; wrLimit = wlim;
    wrDpl = wdpl; wrWritable = wwr;
    reqValid = doReq; reqKind = 2'(kind); reqOvrEn = oEn; reqOvrSeg = 3'(oSeg);
    reqOffset = off; reqWrite = wrt;
    if (doWr && wseg < 6) begin
      if (!peMode) begin
        mBase[wseg] = {12'h0, wsel, 4'h0}; mLimit[wseg] = 32'hFFFF;
        mDpl[wseg] = 2'd0; mWr[wseg] = 1'b1;
      end else begin
        mBase[wseg] = wbase; mLimit[wseg] = wlim; mDpl[wseg] = wdpl; mWr[wseg] = wwr;
      end
    end
    s = pickSeg(kind, oEn, oSeg);
    eAddr = mBase[s] + off;
    if (!peMode && !a20En) eAddr[20] = 1'b0;
    eLim = off > mLimit[s];
    eProt = peMode && ((((kind == 0) || (kind == 3)) && (mDpl[1] > mDpl[s])) ||
                       ((kind != 1) && wrt && !mWr[s]));
    @(posedge clk);
    #1;
    if (doReq) begin
      chk({tag, " valid"}, 64'(outValid), 64'(!eLim && !eProt));
      chk({tag, " limit"}, 64'(outLimitFault), 64'(eLim));
      chk({tag, " prot"},  64'(outProtFault), 64'(eProt));
      chk({tag, " addr"},  64'(outAddr), 64'(eAddr));
    end else begin
      chk({tag, " idle"}, 64'({outValid, outLimitFault, outProtFault}), 64'(0));
    end
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
  endtask

  task automatic ld(input int seg, input logic [15:0] sel, input logic [31:0] b,
                    input logic [31:0] l, input logic [1:0] d, input bit w);
    step(1, seg, sel, b, l, d, w, 0, 0, 0, 0, 32'h0, 0, "load R12");
  endtask

  task automatic rq(input int kind, input bit oEn, input int oSeg,
                    input logic [31:0] off, input bit wrt, input string tag);
    step(0, 0, 16'h0, 32'h0, 32'h0, 2'd0, 0, 1, kind, oEn, oSeg, off, wrt, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      mBase[i] = 0; mLimit[i] = 32'hFFFF; mDpl[i] = 0; mWr[i] = 1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 outputs after reset", 64'({outValid, outLimitFault, outProtFault}), 64'(0));
    // R1: reset caches give base 0, limit 0xFFFF
    for (int k = 0; k < 4; k++) rq(k, 0, 0, 32'h0000_FFFF, 0, "R1 reset cache");
    rq(0, 0, 0, 32'h0001_0000, 0, "R1 reset limit");

    // R2 R4 R5 R7: real-mode sweep over every slot, kind and override code
    a20En = 1'b1;
    for (int s = 0; s < 6; s++) ld(s, 16'(16'h1234 + s * 16'h1111), 0, 0, 0, 0);
    for (int o = 0; o < 8; o++) begin
      rq(0, 1, o, 32'h0, 0, "R5 override");
      rq(0, 1, o, 32'hFFFF, 0, "R5 override top");
      rq(0, 1, o, 32'h1_0000, 0, "R7 real limit");
      rq(0, 0, o, 32'h8000, 1, "R5 no override");
    end
    for (int k = 1; k < 4; k++) begin
      rq(k, 1, 4, 32'h0, 0, "R4 fixed slot");
      rq(k, 1, 5, 32'hFFFF, 1, "R4 fixed slot top");
      rq(k, 0, 0, 32'h1_0000, 0, "R4 fixed slot limit");
    end

    // R3: gate on bit 20
    ld(3, 16'hFFFF, 0, 0, 0, 0);
    a20En = 1'b0;
    rq(0, 0, 0, 32'h10, 0, "R3 wrap");
    rq(0, 0, 0, 32'hFFFF, 0, "R3 wrap top");
    a20En = 1'b1;
    rq(0, 0, 0, 32'h10, 0, "R3 no wrap");
    rq(0, 0, 0, 32'hFFFF, 0, "R3 no wrap top");

    // R13: invalid slot codes change nothing
    step(1, 6, 16'hABCD, 32'h5555_0000, 32'h1, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, "R13 write6");
    step(1, 7, 16'hBCDE, 32'h6666_0000, 32'h1, 2'd3, 0, 0, 0, 0, 0, 32'h0, 0, "R13 write7");
    for (int o = 0; o < 6; o++) rq(0, 1, o, 32'h4, 0, "R13 untouched");

    // R11: same-cycle load and use, real mode
    step(1, 3, 16'h2000, 0, 0, 0, 0, 1, 0, 0, 0, 32'h5, 0, "R11 write-first");

    // protected mode
    peMode = 1'b1;
    ld(1, 16'h8, 32'h0, 32'hFFFF_FFFF, 2'd0, 1);
    ld(3, 16'h10, 32'h4000_0000, 32'hFFFF_FFFF, 2'd0, 0);
    rq(0, 0, 0, 32'h1234, 0, "R6 descriptor base");
    rq(0, 0, 0, 32'h8000_0000, 0, "R6 large offset");
    rq(0, 0, 0, 32'h1234, 1, "R9 read-only write");
    rq(2, 0, 0, 32'h10, 1, "R9 writable stack");
    ld(0, 16'h18, 32'h1000, 32'h1000, 2'd0, 1);
    rq(3, 0, 0, 32'h1000, 1, "R7 at limit");
    rq(3, 0, 0, 32'h1001, 1, "R7 past limit");
    ld(4, 16'h20, 32'hFFFF_F000, 32'hFFFF_FFFF, 2'd3, 1);
    rq(0, 1, 4, 32'h2000, 0, "R6 wrap");
    ld(1, 16'h2B, 32'h0, 32'hFFFF_FFFF, 2'd3, 1);
    rq(0, 0, 0, 32'h40, 0, "R8 outer to inner data");
    rq(0, 1, 4, 32'h40, 0, "R8 equal level");
    rq(3, 0, 0, 32'h40, 0, "R8 string dest");
    rq(1, 0, 0, 32'h40, 0, "R8 fetch unchecked");
    rq(2, 0, 0, 32'h40, 0, "R8 stack unchecked");
    // R11: code slot level loaded in the same cycle as a data request
    step(1, 1, 16'h8, 32'h0, 32'hFFFF_FFFF, 2'd0, 1, 1, 0, 0, 0, 32'h40, 0, "R11 cpl bypass");

    // R10: cache survives leaving protection
    ld(5, 16'h30, 32'h0, 32'hFFFF_FFFF, 2'd0, 1);
    peMode = 1'b0;
    rq(0, 1, 5, 32'h0020_0000, 1, "R10 unreal");
    a20En = 1'b0;
    rq(0, 1, 5, 32'h0030_0000, 0, "R10 unreal gated");
    rq(0, 0, 0, 32'h1234, 1, "R8 real no checks");
    ld(5, 16'h10, 0, 0, 0, 0);
    rq(0, 1, 5, 32'h0020_0000, 0, "R10 reload");

    // R12: idle cycle
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0, "R12 quiet");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule